// File: doc/BRIEF.md
# Write-Twice Guarded Control Register

This block holds one safety-critical control word, such as the setting of a watchdog. A single bus write cannot change it. Software must send two writes to the register address, back to back. The first write is parked in a pending stage. The stored value moves to the parked word only when the second write has the expected relation to it. A lone write, a stray write, or a badly formed second write leaves the stored word untouched. Reads keep returning the old value in those cases.

A mode input selects the rule for the second write:

- **Inverted partner:** the second write must be the bitwise inverse of the first. This is the default.
- **Repeated partner:** the second write must be the same word again.
- **Keyed:** the register first has to be armed by writing a key word to a separate key address. A pair with an inverted partner then commits, and one commit uses up the arm.

A sticky reject flag records every abandoned or refused sequence. A one-cycle commit pulse marks each accepted pair, so a monitor can update its expected value only when a pair completes.

Top module: `guarded_ctrl_reg`

## Requirements
- R1: After reset the stored word equals the RESET_VAL parameter. The reject flag and the commit pulse are low, and no pending first write exists.
- R2: With mode 0, a write of X to the register address is followed on the next write by ~X to the same address. The stored word becomes X, and the commit pulse is high for exactly the one cycle after the second write.
- R3: A read at the register address returns the stored word combinationally. Any other address reads zero. A write with no valid partner never changes the stored word.
- R4: If a second write does not match the rule, nothing commits and the reject flag sets. That write becomes the new pending first write, so a following correct partner commits it.
- R5: With mode 1, the second write must equal the first exactly for the pair to commit.
- R6: With mode 2, a register write while not armed is refused, sets the reject flag and leaves nothing pending. Writing KEY_WORD to KEY_ADDR arms the register. A write of any other word there does not arm it. An armed inverted pair commits, and the commit clears the arm.
- R7: Any write to another address while a first write is pending discards the pending word and sets the reject flag. The key address counts as another address.
- R8: A pending first write can be completed by a second write up to TIMEOUT cycles after it. With no bus write for TIMEOUT cycles, the pending word expires and the reject flag sets.
- R9: Once set, the reject flag stays high until reset, including across later successful commits.
- R10: Mode 3 applies the same inverted-partner rule as mode 0.
- R11: The commit pulse is never high in two consecutive cycles, and it is high only after an accepted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Pair rule: 0 inverted, 1 repeated, 2 keyed, 3 inverted |
| busAddr | input | ADDR_W | Access address |
| busWe | input | 1 | Write enable, one write per high cycle |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, the stored word at the register address |
| ctrlValue | output | DATA_W | Stored control word driven to the controlled function |
| commitPulse | output | 1 | One-cycle pulse after an accepted pair |
| rejectFlag | output | 1 | Sticky flag for refused or abandoned sequences |

## Verification
The bench builds the block with TIMEOUT set to 4 and keeps the default addresses, key word and RESET_VAL of 0x000000FF. The short timeout makes both sides of the expiry boundary reachable in a few cycles: a partner arriving exactly TIMEOUT cycles late, and one arriving a cycle later. The fixed key and addresses let the vectors cover arming, a wrong key, a spent arm, and interruption by the key address within one run.

// File: rtl/guarded_reg_pkg.sv
package guarded_reg_pkg;

  typedef enum logic [1:0] {
    PAIR_INVERT     = 2'd0,
    PAIR_REPEAT     = 2'd1,
    PAIR_KEYED      = 2'd2,
    PAIR_INVERT_ALT = 2'd3
  } pair_mode_e;

  typedef struct packed {
    logic loadPending;
    logic commit;
  } ctrl_strobe_t;

endpackage

// File: rtl/guarded_reg_data.sv
module guarded_reg_data
  import guarded_reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      strobe,
  input  pair_mode_e        mode,
  input  logic [DATA_W-1:0] wrData,
  output logic              pairMatch,
  output logic [DATA_W-1:0] ctrlValue
);

  logic [DATA_W-1:0] pendingVal;

  // Partner check against the parked first word
  always_comb begin
    unique case (mode)
      PAIR_REPEAT: pairMatch = (wrData == pendingVal);
      default:     pairMatch = (wrData == ~pendingVal);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendingVal <= '0;
    end else if (strobe.loadPending) begin
      pendingVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlValue <= RESET_VAL;
    end else if (strobe.commit) begin
      ctrlValue <= pendingVal;
    end
  end

  // R3: stored word only moves on a commit strobe
  p_hold_without_commit_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.commit |=> $stable(ctrlValue));

  // R2: a commit installs the parked first word
  p_commit_takes_pending_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |=> ctrlValue == $past(pendingVal));

endmodule

// File: rtl/guarded_reg_ctrl.sv
module guarded_reg_ctrl
  import guarded_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter logic [ADDR_W-1:0] KEY_ADDR = '0,
  parameter logic [DATA_W-1:0] KEY_WORD = '0,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pair_mode_e        mode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              pairMatch,
  output ctrl_strobe_t      strobe,
  output logic              commitPulse,
  output logic              rejectFlag
);

  localparam int AGE_W = $clog2(TIMEOUT + 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(TIMEOUT - 1);

  logic             pendingValid;
  logic [AGE_W-1:0] age;
  logic             armed;

  logic hitReg, hitKey, hitOther, keyed, gateOpen;
  logic expire, acceptPair, badPair, gateReject, rejectEvent;

  always_comb begin
    hitReg     = busWe && (busAddr == REG_ADDR);
    hitKey     = busWe && (busAddr == KEY_ADDR);
    hitOther   = busWe && !hitReg;
    keyed      = (mode == PAIR_KEYED);
    gateOpen   = !keyed || armed;
    expire     = pendingValid && !busWe && (age == AGE_LAST);
    acceptPair = hitReg && gateOpen && pendingValid && pairMatch;
    badPair    = hitReg && gateOpen && pendingValid && !pairMatch;
    gateReject = hitReg && !gateOpen;
    rejectEvent = badPair || gateReject || expire || (hitOther && pendingValid);
    strobe.commit      = acceptPair;
    strobe.loadPending = hitReg && gateOpen && !acceptPair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendingValid <= 1'b0;
      age          <= '0;
    end else begin
      if (acceptPair || gateReject || hitOther || expire) begin
        pendingValid <= 1'b0;
      end else if (strobe.loadPending) begin
        pendingValid <= 1'b1;
      end
      if (strobe.loadPending) begin
        age <= '0;
      end else if (pendingValid && !busWe) begin
        age <= age + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (hitKey && keyed && (busWdata == KEY_WORD)) begin
      armed <= 1'b1;
    end else if (acceptPair) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commitPulse <= 1'b0;
      rejectFlag  <= 1'b0;
    end else begin
      commitPulse <= acceptPair;
      rejectFlag  <= rejectFlag || rejectEvent;
    end
  end

  // R11: no back-to-back commit pulses
  p_pulse_single_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    commitPulse |=> !commitPulse);

  // R9: reject flag is sticky
  p_reject_sticky_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    rejectFlag |=> rejectFlag);

  // R8: pending age never passes the window
  p_age_bound_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    pendingValid |-> age < AGE_W'(TIMEOUT));

  // R6: a keyed commit spends the arm
  p_arm_spent_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.commit && keyed) |=> !armed);

  // R7: a foreign write leaves nothing pending
  p_foreign_clears_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    hitOther |=> !pendingValid);

endmodule

// File: rtl/guarded_ctrl_reg.sv
module guarded_ctrl_reg
  import guarded_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h14,
  parameter logic [DATA_W-1:0] KEY_WORD  = 32'hA5C3_9E17,
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_00FF,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] ctrlValue,
  output logic              commitPulse,
  output logic              rejectFlag
);

  pair_mode_e   modeSel;
  ctrl_strobe_t strobe;
  logic         pairMatch;

  assign modeSel  = pair_mode_e'(mode);
  assign busRdata = (busAddr == REG_ADDR) ? ctrlValue : '0;

  guarded_reg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
    .KEY_ADDR(KEY_ADDR), .KEY_WORD(KEY_WORD), .TIMEOUT(TIMEOUT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(modeSel), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .pairMatch(pairMatch),
    .strobe(strobe), .commitPulse(commitPulse), .rejectFlag(rejectFlag)
  );

  guarded_reg_data #(
    .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .mode(modeSel),
    .wrData(busWdata), .pairMatch(pairMatch), .ctrlValue(ctrlValue)
  );

  // R1: reset state at the first active cycle
  p_reset_state_r1 : assert property (@(posedge clk)
    !rst_n |=> (rst_n -> (!commitPulse && !rejectFlag)));

endmodule

// File: tb/guarded_ctrl_reg_bench.sv
`timescale 1ns/1ps
module guarded_ctrl_reg_bench;

  localparam int TOUT = 4;
  localparam logic [7:0]  RA = 8'h10, KA = 8'h14, OA = 8'h20;
  localparam logic [31:0] KW = 32'hA5C3_9E17, RV = 32'h0000_00FF;

  logic clk = 1'b0, rst_n = 1'b0, busWe = 1'b0, commitPulse, rejectFlag;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0, busRdata, ctrlValue;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  guarded_ctrl_reg #(.TIMEOUT(TOUT)) u_guarded_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .ctrlValue(ctrlValue),
    .commitPulse(commitPulse), .rejectFlag(rejectFlag)
  );

  // {mode, addr, we, data, expValue, expPulse, expReject}
  localparam int NV = 15;
  localparam logic [76:0] VEC [NV] = '{
    {2'd0, RA, 1'b1, 32'h1234_5678, RV,            1'b0, 1'b0}, // R2 first
    {2'd0, RA, 1'b1, 32'hEDCB_A987, 32'h1234_5678, 1'b1, 1'b0}, // R2 commit
    {2'd0, RA, 1'b0, 32'h0000_0000, 32'h1234_5678, 1'b0, 1'b0}, // R11 pulse drops
    {2'd0, RA, 1'b1, 32'hAAAA_0000, 32'h1234_5678, 1'b0, 1'b0}, // R4 first
    {2'd0, RA, 1'b1, 32'hAAAA_0000, 32'h1234_5678, 1'b0, 1'b1}, // R4 mismatch
    {2'd0, RA, 1'b1, 32'h5555_FFFF, 32'hAAAA_0000, 1'b1, 1'b1}, // R4 re-paired
    {2'd1, RA, 1'b1, 32'h0BAD_F00D, 32'hAAAA_0000, 1'b0, 1'b1}, // R5 first
    {2'd1, RA, 1'b1, 32'h0BAD_F00D, 32'h0BAD_F00D, 1'b1, 1'b1}, // R5 commit
    {2'd2, RA, 1'b1, 32'h1111_1111, 32'h0BAD_F00D, 1'b0, 1'b1}, // R6 unarmed
    {2'd2, KA, 1'b1, KW,            32'h0BAD_F00D, 1'b0, 1'b1}, // R6 arm
    {2'd2, RA, 1'b1, 32'h1111_1111, 32'h0BAD_F00D, 1'b0, 1'b1}, // R6 first
    {2'd2, RA, 1'b1, 32'hEEEE_EEEE, 32'h1111_1111, 1'b1, 1'b1}, // R6 commit
    {2'd2, RA, 1'b1, 32'h2222_2222, 32'h1111_1111, 1'b0, 1'b1}, // R6 arm spent
    {2'd3, RA, 1'b1, 32'h3333_3333, 32'h1111_1111, 1'b0, 1'b1}, // R10 first
    {2'd3, RA, 1'b1, 32'hCCCC_CCCC, 32'h3333_3333, 1'b1, 1'b1}  // R10 commit
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    busWe = 1'b0; mode = 2'd0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] m, logic [7:0] a, logic [31:0] d);
    mode = m; busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic idle(int n);
    busWe = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung expected finish");
    finishRun();
  end

  initial begin
    doReset();
    // R1 reset state, R3 read decode
    busAddr = RA; #1;
    check("R1 value", ctrlValue, RV);
    check("R1 reject", {31'd0, rejectFlag}, 32'd0);
    check("R1 pulse", {31'd0, commitPulse}, 32'd0);
    check("R3 read reg", busRdata, RV);
    busAddr = OA; #1;
    check("R3 read other", busRdata, 32'd0);

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][76:75]; busAddr = VEC[i][74:67];
      busWe = VEC[i][66]; busWdata = VEC[i][65:34];
      @(negedge clk);
      busWe = 1'b0;
      check($sformatf("vec%0d value", i), ctrlValue, VEC[i][33:2]);
      check($sformatf("vec%0d pulse", i), {31'd0, commitPulse}, {31'd0, VEC[i][1]});
      check($sformatf("vec%0d reject", i), {31'd0, rejectFlag}, {31'd0, VEC[i][0]});
    end

    // R3 / R8: lone write expires, old value kept
    doReset();
    wr(2'd0, RA, 32'h600D_CAFE);
    idle(6);
    busAddr = RA; #1;
    check("R3 lone write value", ctrlValue, RV);
    check("R3 lone write read", busRdata, RV);
    check("R8 expiry reject", {31'd0, rejectFlag}, 32'd1);
    // R9 sticky across a good commit
    wr(2'd0, RA, 32'h0000_0001);
    wr(2'd0, RA, 32'hFFFF_FFFE);
    check("R9 commit", ctrlValue, 32'h0000_0001);
    check("R9 sticky", {31'd0, rejectFlag}, 32'd1);

    // R8: partner exactly TIMEOUT cycles after first write
    doReset();
    wr(2'd0, RA, 32'h0F0F_1234);
    idle(TOUT - 1);
    wr(2'd0, RA, ~32'h0F0F_1234);
    check("R8 last slot value", ctrlValue, 32'h0F0F_1234);
    check("R8 last slot pulse", {31'd0, commitPulse}, 32'd1);
    check("R8 last slot reject", {31'd0, rejectFlag}, 32'd0);

    // R8: one cycle too late
    doReset();
    wr(2'd0, RA, 32'h0F0F_1234);
    idle(TOUT);
    wr(2'd0, RA, ~32'h0F0F_1234);
    check("R8 late value", ctrlValue, RV);
    check("R8 late reject", {31'd0, rejectFlag}, 32'd1);

    // R7: intervening write elsewhere
    doReset();
    wr(2'd0, RA, 32'h7777_0000);
    wr(2'd0, OA, 32'h0000_0000);
    wr(2'd0, RA, 32'h8888_FFFF);
    check("R7 interrupted value", ctrlValue, RV);
    check("R7 interrupted reject", {31'd0, rejectFlag}, 32'd1);

    // R6: wrong key does not arm
    doReset();
    wr(2'd2, KA, 32'h1234_5678);
    wr(2'd2, RA, 32'h4444_4444);
    check("R6 wrong key reject", {31'd0, rejectFlag}, 32'd1);
    wr(2'd2, RA, 32'hBBBB_BBBB);
    check("R6 wrong key value", ctrlValue, RV);

    finishRun();
  end

endmodule